// File: doc/BRIEF.md
# Filtered Multi-Domain Reset Synchronizer

This block turns one raw, asynchronous, active-low reset into a separate synchronous active-low reset for each of several clock domains. Each domain has its own chain. The raw input first crosses into the domain through two flip-flops. A counter then qualifies it, so that a request counts only after it has been seen asserted on a given number of consecutive clock edges. Shorter activity is treated as noise and dropped. A qualified request drives the domain's reset output low, and the output stays low for at least a set number of cycles after the last qualified sample.

Domains whose clock comes from a PLL take a lock flag. That flag is synchronized into the domain. While it is low the domain is held in reset, and after it rises the full stretch interval runs before the reset is released. If lock is lost while the domain is running, its reset is asserted again. The outputs are meant to be combined with the data path of downstream registers as a synchronous reset, not wired to asynchronous clear pins.

Top module: `rst_multi_dom_filter`

## Requirements
- R1: After power-up every bit of `rst_no` is 0 (0 means "in reset", 1 means "running") before the first clock edge.
- R2: A low pulse on `rst_ni` that starts and ends between two rising edges of a domain clock causes no reset in any domain.
- R3: A low pulse on `rst_ni` seen on 1 to FILT_LEN-1 consecutive rising edges causes no reset in any domain.
- R4: If `rst_ni` is first sampled low at rising edge k and is held for L ≥ FILT_LEN edges, `rst_no` of that domain goes to 0 at edge k+FILT_LEN+1.
- R5: After such a pulse, with its last low sample at edge k+L-1, `rst_no` returns to 1 at edge k+L+MIN_WIDTH+1. The output is therefore low for L-FILT_LEN+MIN_WIDTH cycles, and never fewer than MIN_WIDTH. Release also requires that the synchronized input is no longer asserted.
- R6: Every domain has an independent chain. Domains on the same clock with lock satisfied produce identical outputs.
- R7: A domain whose bit in PLL_MASK is 1 stays in reset while its `lock_i` bit is 0. If `lock_i` is first sampled high at edge k, the domain is released at edge k+MIN_WIDTH+1.
- R8: If `lock_i` of a gated domain is first sampled low at edge k, that domain's `rst_no` is 0 after edge k+2. Its release then follows R7.
- R9: If a lock loss reaches the output stage on the same edge that the stretch would have ended, the domain stays in reset. Release then waits for lock per R7.
- R10: A domain whose bit in PLL_MASK is 0 ignores its `lock_i` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | NUM_DOM | One clock per domain |
| rst_ni | input | 1 | Raw asynchronous reset request, active low |
| lock_i | input | NUM_DOM | Per-domain PLL lock flag, active high |
| rst_no | output | NUM_DOM | Per-domain synchronous reset, active low |

## Verification
Two functions can meet on one clock edge: the end of the stretch countdown, which would release the domain, and the arrival of a synchronized loss of lock, which would hold it. The bench provokes this by lowering the lock of one gated domain exactly MIN_WIDTH+FILT_LEN-1 cycles after a qualified pulse begins. The lock loss then reaches the output stage on the edge at which an ungated domain is released. The bench judges the result at the ports. The ungated domain must release on schedule, and the gated one must stay low until MIN_WIDTH+1 edges after lock is sampled high again.

// File: rtl/rst_filt_pkg.sv
package rst_filt_pkg;
  // counter width able to hold values 0 .. v-1 (at least one bit)
  function automatic int unsigned cnt_w(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/rst_sync_2ff.sv
module rst_sync_2ff #(
  parameter bit INIT = 1'b0
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o
);
  logic s1_q = INIT;
  logic s2_q = INIT;

  always_ff @(posedge clk_i) begin
    s1_q <= d_i;
    s2_q <= s1_q;
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rst_pulse_filter.sv
module rst_pulse_filter
  import rst_filt_pkg::*;
#(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic req_i,
  output logic hit_o
);
  localparam int unsigned CW = cnt_w(FILT_LEN);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [CW-1:0] run_q = '0;

  // saturating run length of consecutive asserted samples
  always_ff @(posedge clk_i) begin
    if (!req_i)            run_q <= '0;
    else if (run_q != LAST) run_q <= run_q + 1'b1;
  end

  assign hit_o = req_i && (run_q == LAST);
endmodule

// File: rtl/rst_dom_chain.sv
module rst_dom_chain
  import rst_filt_pkg::*;
#(
  parameter int unsigned FILT_LEN  = 4,
  parameter int unsigned MIN_WIDTH = 6,
  parameter bit          GATED     = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  output logic rst_no
);
  localparam int unsigned HW = cnt_w(MIN_WIDTH);
  localparam logic [HW-1:0] RELOAD = HW'(MIN_WIDTH - 1);

  logic rst_s, lock_s, req, hit, hold;
  logic [HW-1:0] hcnt_q = RELOAD;
  logic rst_q = 1'b0;

  rst_sync_2ff #(.INIT(1'b0)) u_rst_sync (
    .clk_i (clk_i),
    .d_i   (rst_ni),
    .q_o   (rst_s)
  );

  generate
    if (GATED) begin : g_lock
      rst_sync_2ff #(.INIT(1'b0)) u_lock_sync (
        .clk_i (clk_i),
        .d_i   (lock_i),
        .q_o   (lock_s)
      );
    end else begin : g_nolock
      logic unused_lock;
      assign unused_lock = lock_i;
      assign lock_s = 1'b1;
    end
  endgenerate

  assign req = ~rst_s;

  rst_pulse_filter #(.FILT_LEN(FILT_LEN)) u_filter (
    .clk_i (clk_i),
    .req_i (req),
    .hit_o (hit)
  );

  // qualified request or missing lock restarts the stretch
  assign hold = hit | ~lock_s;

  always_ff @(posedge clk_i) begin
    if (hold) begin
      hcnt_q <= RELOAD;
      rst_q  <= 1'b0;
    end else begin
      if (hcnt_q != '0) hcnt_q <= hcnt_q - 1'b1;
      if (hcnt_q == '0 && !req) rst_q <= 1'b1;
    end
  end

  assign rst_no = rst_q;

  // checker state: length of the current low run, saturating at MIN_WIDTH
  localparam int unsigned LW = $clog2(MIN_WIDTH + 1);
  logic [LW-1:0] low_run_q = '0;
  always_ff @(posedge clk_i) begin
    if (rst_q)                      low_run_q <= '0;
    else if (low_run_q != LW'(MIN_WIDTH)) low_run_q <= low_run_q + 1'b1;
  end

  p_hit_asserts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> !rst_q);
  p_min_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> (low_run_q >= LW'(MIN_WIDTH)));
  p_release_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> $past(!req));

  generate
    if (FILT_LEN > 1) begin : g_filt_chk
      p_filter_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |-> $past(req));
    end
    if (GATED) begin : g_lock_chk
      p_lock_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_q) |-> $past(lock_s));
      p_lock_loss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_s |=> !rst_q);
    end
  endgenerate
endmodule

// File: rtl/rst_multi_dom_filter.sv
module rst_multi_dom_filter #(
  parameter int unsigned          NUM_DOM   = 3,
  parameter int unsigned          FILT_LEN  = 4,
  parameter int unsigned          MIN_WIDTH = 6,
  parameter logic [NUM_DOM-1:0]   PLL_MASK  = 3'b110
) (
  input  logic [NUM_DOM-1:0] clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DOM-1:0] lock_i,
  output logic [NUM_DOM-1:0] rst_no
);
  generate
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      rst_dom_chain #(
        .FILT_LEN  (FILT_LEN),
        .MIN_WIDTH (MIN_WIDTH),
        .GATED     (PLL_MASK[d])
      ) u_chain (
        .clk_i  (clk_i[d]),
        .rst_ni (rst_ni),
        .lock_i (lock_i[d]),
        .rst_no (rst_no[d])
      );
    end
  endgenerate
endmodule

// File: tb/tb_rst_multi_dom_filter.sv
`timescale 1ns/1ps
module tb_rst_multi_dom_filter;
  localparam int NDOM = 3;
  localparam int N    = 4;
  localparam int M    = 6;
  localparam int NVEC = 6;
  // {pulse length in cycles, expected low cycles}
  localparam int VEC [NVEC][2] = '{'{1, 0}, '{2, 0}, '{3, 0},
                                   '{4, 6}, '{5, 7}, '{10, 12}};

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic [NDOM-1:0] lock = '0;
  logic [NDOM-1:0] rst_no;
  int total = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rst_multi_dom_filter #(.NUM_DOM(NDOM), .FILT_LEN(N), .MIN_WIDTH(M),
                         .PLL_MASK(3'b110)) dut (
    .clk_i  ({NDOM{clk}}),
    .rst_ni (rst_ni),
    .lock_i (lock),
    .rst_no (rst_no)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive a low pulse of len cycles, count low samples on domain 0
  task automatic pulse(input int len, input int exp_low);
    int lows = 0, first = -1, mism = 0;
    for (int i = 0; i < len + N + M + 8; i++) begin
      @(negedge clk);
      rst_ni = (i < len) ? 1'b0 : 1'b1;
      if (!rst_no[0]) begin
        lows++;
        if (first < 0) first = i;
      end
      if (rst_no != {NDOM{rst_no[0]}}) mism++;
    end
    if (exp_low == 0) chk("R3 short pulse low cycles", lows, 0);
    else begin
      chk("R5 stretched low cycles", lows, exp_low);
      chk("R4 assert latency", first, N + 2);
    end
    chk("R6 domains agree", mism, 0);
  endtask

  initial begin
    #1;
    chk("R1 power-up asserted", int'(rst_no), 0);
    repeat (20) @(negedge clk);
    chk("R10 ungated released without lock", int'(rst_no[0]), 1);
    chk("R7 gated held without lock", int'(rst_no[2:1]), 0);

    // lock of domain 1 rises
    for (int i = 0; i <= M + 2; i++) begin
      @(negedge clk);
      if (i == 0) lock[1] = 1'b1;
      if (i == M + 1) chk("R7 held before release edge", int'(rst_no[1]), 0);
      if (i == M + 2) begin
        chk("R7 released after lock", int'(rst_no[1]), 1);
        chk("R7 other gated domain still held", int'(rst_no[2]), 0);
      end
    end
    lock[2] = 1'b1;
    repeat (M + 6) @(negedge clk);
    chk("R7 all released", int'(rst_no), 7);

    for (int v = 0; v < NVEC; v++) pulse(VEC[v][0], VEC[v][1]);

    // sub-cycle glitch between edges
    @(posedge clk); #0.5 rst_ni = 1'b0; #1.0 rst_ni = 1'b1;
    begin
      int lows = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (rst_no != 3'b111) lows++;
      end
      chk("R2 sub-cycle glitch ignored", lows, 0);
    end

    // loss of lock on domains 0 and 1
    for (int i = 0; i <= 5; i++) begin
      @(negedge clk);
      if (i == 0) lock[1:0] = 2'b00;
      if (i == 2) chk("R8 not yet asserted", int'(rst_no[1]), 1);
      if (i == 3) chk("R8 asserted after lock loss", int'(rst_no[1]), 0);
      if (i == 5) chk("R10 ungated ignores lock loss", int'(rst_no[0]), 1);
    end
    for (int j = 0; j <= M + 2; j++) begin
      @(negedge clk);
      if (j == 0) lock[1:0] = 2'b11;
      if (j == M + 1) chk("R8 held until relock stretch", int'(rst_no[1]), 0);
      if (j == M + 2) chk("R8 released after relock", int'(rst_no[1]), 1);
    end
    repeat (4) @(negedge clk);

    // lock loss arriving on the release edge of a qualified pulse
    begin
      int r = N + M + 4;
      for (int i = 0; i <= r + M + 2; i++) begin
        @(negedge clk);
        rst_ni = (i < N) ? 1'b0 : 1'b1;
        if (i == N + M - 1) lock[1] = 1'b0;
        if (i == r) lock[1] = 1'b1;
        if (i == N + M + 1) chk("R9 ungated still low before release", int'(rst_no[0]), 0);
        if (i == N + M + 2) begin
          chk("R9 ungated released on time", int'(rst_no[0]), 1);
          chk("R9 lock loss wins release edge", int'(rst_no[1]), 0);
          chk("R9 other gated released", int'(rst_no[2]), 1);
        end
        if (i == r + M + 1) chk("R9 held until relock", int'(rst_no[1]), 0);
        if (i == r + M + 2) chk("R9 released after relock", int'(rst_no[1]), 1);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - errors, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - errors, total);
      $finish;
    end
  end
endmodule